// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialiser

This block prepares an asynchronous DRAM for use after power is applied and then keeps its contents alive with distributed CAS-before-RAS (CBR) refresh. Once reset is released it waits out a long start-up pause. It then runs a fixed number of warm-up CBR cycles on its own, and only after that does it raise `ready`. Because the device steps through rows with its own internal counter during a CBR cycle, the block never drives an address.

In normal operation an interval timer adds one owed refresh to a saturating debt counter at a fixed period. The block asks the access sequencer for the strobes with `ref_req` whenever that debt is nonzero. While `ref_gnt` is held, the block runs one complete CBR cycle per owed refresh, back to back, until the debt is cleared. A late grant therefore catches up on every refresh missed in the meantime, up to the saturation limit.

All timing is given in clock cycles. With the default 10 ns clock, the defaults give a 200 µs pause and a 15.6 µs refresh period. They also give at least 10 ns of CAS set-up before RAS falls, a 50 ns RAS pulse and 30 ns of precharge.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `ras_n`, `cas_n` and `we_n` are 1, and `strobe_oe`, `ready` and `ref_req` are 0.
- R2: For at least `PAUSE_CYC` cycles after reset is released, `cas_n` and `ras_n` stay high. The warm-up cycles that follow run with `ref_gnt` held low, and the first CAS fall comes no later than `PAUSE_CYC + T_RP_CYC + 2` cycles after release.
- R3: Exactly `WARMUP_CNT` CBR cycles (RAS falling edges) occur before `ready` rises. After that, `ready` stays high until the next reset.
- R4: In every cycle the block drives, `cas_n` is low for at least `T_CSR_CYC` cycles before `ras_n` falls and stays low for as long as `ras_n` is low. `we_n` is 1 at every RAS fall.
- R5: Each RAS low pulse lasts exactly `T_RAS_CYC` cycles. `ras_n` has been high for at least `T_RP_CYC` cycles whenever `cas_n` falls.
- R6: The first `ref_req` rises exactly `INTERVAL_CYC` cycles after `ready` rises. After that, one refresh is owed every `INTERVAL_CYC` cycles.
- R7: `ref_req` is high exactly when `ready` is high and the owed count is nonzero. The owed count saturates at `DEBT_MAX`, so a grant given after more than `DEBT_MAX` missed periods produces exactly `DEBT_MAX` cycles before `ref_req` falls.
- R8: Once `ready` is high, no cycle starts without `ref_gnt`, even while `ref_req` is high. `strobe_oe` stays 0 and `ras_n` does not fall.
- R9: `ref_gnt` while nothing is owed has no effect: `strobe_oe` stays 0 and no RAS or CAS edge occurs.
- R10: One owed refresh and a grant produce exactly one CBR cycle, after which `ref_req` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Grant from the access sequencer; the strobes belong to this block while it is high |
| ref_req | output | 1 | At least one refresh is owed and the device is ready |
| ready | output | 1 | Pause and warm-up done; the device may be accessed |
| strobe_oe | output | 1 | This block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high by this block |

## Verification
The assertions take it that the sequencer holds `ref_gnt` high from the moment it grants until `ref_req` has fallen and `strobe_oe` is low. They also take it that the sequencer never withdraws the grant in the middle of a CBR cycle. The stimulus raises the grant only at points where the owed count is known and drops it only after `ref_req` has been seen low. The long no-grant waits are placed between interval ticks, so that no tick lands during a service burst. Before `ready`, the grant is kept low throughout, which matches the rule that warm-up cycles need no handshake.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_CSR,
        PH_ACT,
        PH_POST
    } cbr_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Strobe levels for each phase of a CBR cycle
    function automatic strobe_t phase_strobes(input cbr_phase_e ph);
        strobe_t s;
        s = STROBE_REST;
        case (ph)
            PH_CSR: s.cas_n = 1'b0;
            PH_ACT: begin
                s.cas_n = 1'b0;
                s.ras_n = 1'b0;
            end
            default: ;
        endcase
        return s;
    endfunction

    // Bits needed to hold values 0..n
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ref_pwrup_seq.sv
module ref_pwrup_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned PAUSE_CYC  = 20000,
    parameter int unsigned WARMUP_CNT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_done,
    output logic warm_go,
    output logic ready
);
    localparam int unsigned PW = width_for(PAUSE_CYC);
    localparam int unsigned WW = width_for(WARMUP_CNT);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [WW-1:0] WARM_LAST  = WW'(WARMUP_CNT - 1);

    logic [PW-1:0] pause_cnt;
    logic          pause_done;
    logic [WW-1:0] warm_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_cnt  <= '0;
            pause_done <= 1'b0;
            warm_cnt   <= '0;
            ready      <= 1'b0;
        end else begin
            if (!pause_done) begin
                pause_cnt <= pause_cnt + 1'b1;
                if (pause_cnt == PAUSE_LAST) begin
                    pause_done <= 1'b1;
                end
            end
            if (!ready && cyc_done) begin
                warm_cnt <= warm_cnt + 1'b1;
                if (warm_cnt == WARM_LAST) begin
                    ready <= 1'b1;
                end
            end
        end
    end

    assign warm_go = pause_done && !ready;

endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer
    import dram_ref_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = width_for(INTERVAL_CYC);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter
    import dram_ref_pkg::*;
#(
    parameter int unsigned DEBT_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic owed
);
    generate
        if (DEBT_MAX <= 1) begin : g_flag
            logic flag;
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag <= 1'b0;
                end else if (inc) begin
                    flag <= 1'b1;
                end else if (dec) begin
                    flag <= 1'b0;
                end
            end
            assign owed = flag;
        end else begin : g_count
            localparam int unsigned DW = width_for(DEBT_MAX);
            localparam logic [DW-1:0] TOP = DW'(DEBT_MAX);
            logic [DW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else begin
                    case ({inc, dec})
                        2'b10: if (cnt != TOP) cnt <= cnt + 1'b1;
                        2'b01: if (cnt != '0) cnt <= cnt - 1'b1;
                        default: ;
                    endcase
                end
            end
            assign owed = (cnt != '0);
        end
    endgenerate

endmodule

// File: rtl/ref_cbr_fsm.sv
module ref_cbr_fsm
    import dram_ref_pkg::*;
#(
    parameter int unsigned T_RP_CYC  = 3,
    parameter int unsigned T_CSR_CYC = 1,
    parameter int unsigned T_RAS_CYC = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output logic    busy,
    output logic    done,
    output strobe_t strb
);
    localparam int unsigned CW = width_for(max3(T_RP_CYC, T_CSR_CYC, T_RAS_CYC));
    localparam logic [CW-1:0] RP_LD  = CW'(T_RP_CYC - 1);
    localparam logic [CW-1:0] CSR_LD = CW'(T_CSR_CYC - 1);
    localparam logic [CW-1:0] RAS_LD = CW'(T_RAS_CYC - 1);

    cbr_phase_e     state, nxt;
    logic [CW-1:0]  cnt, nxt_cnt;

    always_comb begin
        nxt     = state;
        nxt_cnt = cnt;
        done    = 1'b0;
        if (state != PH_IDLE && cnt != '0) begin
            nxt_cnt = cnt - 1'b1;
        end else begin
            case (state)
                PH_IDLE: if (start) begin
                    nxt     = PH_PRE;
                    nxt_cnt = RP_LD;
                end
                PH_PRE: begin
                    nxt     = PH_CSR;
                    nxt_cnt = CSR_LD;
                end
                PH_CSR: begin
                    nxt     = PH_ACT;
                    nxt_cnt = RAS_LD;
                end
                PH_ACT: begin
                    nxt     = PH_POST;
                    nxt_cnt = RP_LD;
                end
                PH_POST: begin
                    nxt  = PH_IDLE;
                    done = 1'b1;
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            cnt   <= '0;
            busy  <= 1'b0;
            strb  <= STROBE_REST;
        end else begin
            state <= nxt;
            cnt   <= nxt_cnt;
            busy  <= (nxt != PH_IDLE);
            strb  <= phase_strobes(nxt);
        end
    end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_ref_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 20000,
    parameter int unsigned WARMUP_CNT   = 8,
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned DEBT_MAX     = 8,
    parameter int unsigned T_RP_CYC     = 3,
    parameter int unsigned T_CSR_CYC    = 1,
    parameter int unsigned T_RAS_CYC    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ready,
    output logic strobe_oe,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    logic    warm_go;
    logic    tick;
    logic    owed;
    logic    start;
    logic    done;
    logic    busy;
    strobe_t strb;

    ref_pwrup_seq #(
        .PAUSE_CYC (PAUSE_CYC),
        .WARMUP_CNT(WARMUP_CNT)
    ) u_pwrup (
        .clk     (clk),
        .rst     (rst),
        .cyc_done(done),
        .warm_go (warm_go),
        .ready   (ready)
    );

    ref_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .run (ready),
        .tick(tick)
    );

    // Warm-up completions are not debt; only post-ready cycles pay it off
    ref_debt_counter #(
        .DEBT_MAX(DEBT_MAX)
    ) u_debt (
        .clk (clk),
        .rst (rst),
        .inc (tick),
        .dec (done && ready),
        .owed(owed)
    );

    assign start = !busy && (warm_go || (ready && ref_gnt && owed));

    ref_cbr_fsm #(
        .T_RP_CYC (T_RP_CYC),
        .T_CSR_CYC(T_CSR_CYC),
        .T_RAS_CYC(T_RAS_CYC)
    ) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .busy (busy),
        .done (done),
        .strb (strb)
    );

    assign ref_req   = ready && owed;
    assign strobe_oe = busy;
    assign ras_n     = strb.ras_n;
    assign cas_n     = strb.cas_n;
    assign we_n      = strb.we_n;

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
    parameter int unsigned T_RAS_CYC = 5
) (
    input logic clk,
    input logic rst,
    input logic ref_gnt,
    input logic ref_req,
    input logic ready,
    input logic strobe_oe,
    input logic ras_n,
    input logic cas_n
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || ras_n) begin
            low_run <= '0;
        end else if (low_run != 16'hFFFF) begin
            low_run <= low_run + 1'b1;
        end
    end

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R4

    AST_CAS_THRU_RAS: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n); // R4

    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_run == 16'(T_RAS_CYC))); // R5

    AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $past(ras_n)); // R5

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        (strobe_oe && ready) |-> ref_gnt); // R8

    AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> ready); // R7

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R3

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(
    .T_RAS_CYC(T_RAS_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_gnt  (ref_gnt),
    .ref_req  (ref_req),
    .ready    (ready),
    .strobe_oe(strobe_oe),
    .ras_n    (ras_n),
    .cas_n    (cas_n)
);

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PAUSE      = 2000;
    localparam int WARM       = 8;
    localparam int INTERVAL   = 300;
    localparam int DMAX       = 8;
    localparam int TRP        = 3;
    localparam int TCSR       = 1;
    localparam int TRAS       = 5;
    localparam int WD_LIMIT   = 60000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, ready, strobe_oe, ras_n, cas_n, we_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ras_falls = 0;
    int oe_seen = 0;
    int cas_low_run = 0, ras_low_run = 0, ras_high_run = 0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    int rst_cyc = 0, t_ready = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_ctrl #(
        .PAUSE_CYC(PAUSE), .WARMUP_CNT(WARM), .INTERVAL_CYC(INTERVAL),
        .DEBT_MAX(DMAX), .T_RP_CYC(TRP), .T_CSR_CYC(TCSR), .T_RAS_CYC(TRAS)
    ) dut (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ready(ready), .strobe_oe(strobe_oe), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Strobe monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (!rst) begin
            if (strobe_oe) oe_seen++;
            if (prev_ras && !ras_n) begin
                ras_falls++;
                check(!cas_n && cas_low_run >= TCSR, "R4", "CAS low run before RAS fall",
                      cas_low_run, TCSR);
                check(we_n == 1'b1, "R4", "we_n at RAS fall", we_n, 1);
                if (ready) check(ref_gnt == 1'b1, "R8", "grant during driven cycle", ref_gnt, 1);
            end
            if (!prev_ras && ras_n) begin
                check(ras_low_run == TRAS, "R5", "RAS low width", ras_low_run, TRAS);
                check(prev_cas == 1'b0, "R4", "CAS low through RAS pulse", prev_cas, 0);
            end
            if (prev_cas && !cas_n)
                check(ras_high_run >= TRP, "R5", "RAS high before CAS fall", ras_high_run, TRP);
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic wait_req(input logic lvl, input string req);
        int n = 0;
        while (ref_req !== lvl && n < 5000) begin
            step();
            n++;
        end
        check(ref_req === lvl, req, "ref_req reached level", ref_req, lvl);
    endtask

    task automatic test_reset();
        step();
        check(ras_n && cas_n && we_n, "R1", "strobes in reset", {ras_n, cas_n, we_n}, 7);
        check(!strobe_oe && !ready && !ref_req, "R1", "outputs in reset",
              {strobe_oe, ready, ref_req}, 0);
        rst = 1'b0;
        rst_cyc = cyc;
        step();
        check(ras_n && cas_n && !strobe_oe && !ready, "R1", "first cycle after reset",
              {ras_n, cas_n, strobe_oe, ready}, 12);
    endtask

    task automatic test_pause();
        int d;
        while (cyc - rst_cyc < PAUSE - 1) step();
        check(ras_falls == 0 && cas_n && ras_n, "R2", "no strobe activity during pause",
              ras_falls, 0);
        while (cas_n) step();
        d = cyc - rst_cyc;
        check(d >= PAUSE && d <= PAUSE + TRP + 2, "R2", "first CAS fall after pause", d, PAUSE);
        check(ref_gnt == 1'b0 && strobe_oe, "R2", "warm-up runs without grant", strobe_oe, 1);
    endtask

    task automatic test_warmup();
        int n = 0;
        while (!ready && n < 2000) begin
            step();
            n++;
        end
        t_ready = cyc;
        check(ready == 1'b1, "R3", "ready rose", ready, 1);
        check(ras_falls == WARM, "R3", "warm-up cycle count", ras_falls, WARM);
        check(ref_req == 1'b0, "R7", "no request right after ready", ref_req, 0);
    endtask

    task automatic test_interval();
        wait_req(1'b1, "R6");
        check(cyc - t_ready == INTERVAL, "R6", "first request delay", cyc - t_ready, INTERVAL);
        check(ready == 1'b1, "R3", "ready held", ready, 1);
    endtask

    task automatic test_no_grant();
        int f0 = ras_falls;
        int o0 = oe_seen;
        repeat (50) step();
        check(ras_falls == f0 && oe_seen == o0, "R8", "no cycle without grant",
              ras_falls - f0, 0);
        check(ref_req == 1'b1, "R7", "request held while owed", ref_req, 1);
    endtask

    task automatic test_single();
        int f0 = ras_falls;
        ref_gnt = 1'b1;
        wait_req(1'b0, "R10");
        while (strobe_oe) step();
        ref_gnt = 1'b0;
        step();
        check(ras_falls - f0 == 1, "R10", "one cycle per owed refresh", ras_falls - f0, 1);
    endtask

    task automatic test_idle_grant();
        int f0 = ras_falls;
        int o0 = oe_seen;
        ref_gnt = 1'b1;
        repeat (40) step();
        ref_gnt = 1'b0;
        step();
        check(ras_falls == f0 && oe_seen == o0 && cas_n, "R9", "grant with nothing owed",
              oe_seen - o0, 0);
        check(ref_req == 1'b0, "R7", "no request when nothing owed", ref_req, 0);
    endtask

    task automatic test_saturation();
        int f0;
        while (cyc < t_ready + 11 * INTERVAL + 5) step();
        check(ref_req == 1'b1, "R7", "request after missed periods", ref_req, 1);
        f0 = ras_falls;
        ref_gnt = 1'b1;
        wait_req(1'b0, "R7");
        while (strobe_oe) step();
        ref_gnt = 1'b0;
        repeat (5) step();
        check(ras_falls - f0 == DMAX, "R7", "catch-up saturates", ras_falls - f0, DMAX);
        check(ref_req == 1'b0, "R7", "request low after catch-up", ref_req, 0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WD_LIMIT, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_pause();
        test_warmup();
        test_interval();
        test_no_grant();
        test_single();
        test_idle_grant();
        test_saturation();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule